// File: doc/BRIEF.md
# Segment Table Translation Unit

This block turns a two-part logical address into a physical address. The two parts are a segment number and an offset. It holds an on-chip segment table, where each entry stores a physical base, a length limit, a valid bit and three access permissions (read, write, execute). A separate length register states how many segments are currently in use.

Each translation request carries a segment number, an offset and an access type. The unit checks the request and answers one cycle later with a valid strobe. When every check passes, the answer is the base plus the offset. When a check fails, the answer is a fault code and the address is zero.

The table and the length register are loaded through a simple write port. A request issued in the same cycle as a write still sees the old contents. Every later request sees the new contents.

Top module: `seg_xlate`

## Requirements
- R1: After reset the length register is 0 and `rspValid` is 0. Any request made before the length register is written therefore faults with code 1 (segment out of range).
- R2: `rspValid` is high exactly in the cycle after a cycle with `reqValid` high. While `rspValid` is low, `rspAddr` and `rspFault` are both 0.
- R3: A request whose segment number is greater than or equal to the length register faults with code 1. This check has the highest priority.
- R4: A request with an in-range segment whose entry has its valid bit cleared faults with code 2.
- R5: A request with an in-range, valid segment whose offset is greater than or equal to the entry limit faults with code 3.
- R6: A request that passes R3 to R5 faults with code 4 when its access type is not permitted. The access type encoding is 0 = read, needing permission bit 0; 1 = write, needing bit 1; 2 = execute, needing bit 2; 3 = always denied.
- R7: A request that passes all checks returns fault code 0 and `rspAddr` equal to base plus the zero-extended offset, modulo 2^32. Any faulting response returns `rspAddr` of 0.
- R8: With `cfgWrEn` high, `cfgSel` = 0 writes the entry selected by `cfgIdx` (`cfgBase`, `cfgLimit`, `cfgValid`, `cfgPerm`), and `cfgSel` = 1 writes the length register from `cfgLen`. A request in the same cycle as a write is translated with the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 = table entry, 1 = length register |
| cfgIdx | input | 8 | Entry index for a table write |
| cfgBase | input | 32 | Entry physical base |
| cfgLimit | input | 24 | Entry length limit |
| cfgValid | input | 1 | Entry valid bit |
| cfgPerm | input | 3 | Entry permissions: bit0 read, bit1 write, bit2 execute |
| cfgLen | input | 9 | New length register value (0 to 256) |
| reqValid | input | 1 | Translation request strobe |
| reqSeg | input | 8 | Segment number |
| reqOff | input | 24 | Offset within segment |
| reqAcc | input | 2 | Access type |
| rspValid | output | 1 | Response strobe |
| rspAddr | output | 32 | Physical address, 0 on a fault |
| rspFault | output | 3 | 0 = ok, 1 = range, 2 = invalid, 3 = limit, 4 = permission |

## Verification
Suppose an entry is stored wrongly, or the length register is stale. The first request that touches that entry, or that falls near the length boundary, returns a wrong fault code or a wrong address. This shows up in the response cycle right after that request. If the priority between the checks is wrong, a request that breaks two rules at once reports the lower-ranked code. The bench therefore builds requests that violate several checks together. It also places offsets exactly at the limit and one below it, so that an off-by-one compare changes the code at once. Writes issued in the same cycle as a request reveal any forwarding of new contents, because they flip the result of that one response.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_RANGE = 3'd1,
    FLT_INVAL = 3'd2,
    FLT_LIMIT = 3'd3,
    FLT_PERM  = 3'd4
  } fault_e;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } access_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   tblWr;
    logic   lenWr;
    logic   capture;
    fault_e fault;
  } ctrl_t;

endpackage

// File: rtl/seg_xlate_ctrl.sv
module seg_xlate_ctrl
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 24
) (
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOff,
  input  logic [1:0]       reqAcc,
  input  logic [SEG_W:0]   lenQ,
  input  logic             entValid,
  input  logic [OFF_W-1:0] entLimit,
  input  logic [2:0]       entPerm,
  output ctrl_t            ctrl
);

  logic permOk;

  always_comb begin
    case (access_e'(reqAcc))
      ACC_READ:  permOk = entPerm[0];
      ACC_WRITE: permOk = entPerm[1];
      ACC_EXEC:  permOk = entPerm[2];
      default:   permOk = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.tblWr   = cfgWrEn && !cfgSel;
    ctrl.lenWr   = cfgWrEn && cfgSel;
    ctrl.capture = reqValid;
    if ({1'b0, reqSeg} >= lenQ)  ctrl.fault = FLT_RANGE;
    else if (!entValid)          ctrl.fault = FLT_INVAL;
    else if (reqOff >= entLimit) ctrl.fault = FLT_LIMIT;
    else if (!permOk)            ctrl.fault = FLT_PERM;
    else                         ctrl.fault = FLT_NONE;
  end

endmodule

// File: rtl/seg_xlate_dp.sv
module seg_xlate_dp
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 24,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctrl,
  input  logic [SEG_W-1:0] cfgIdx,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [OFF_W-1:0] cfgLimit,
  input  logic             cfgValid,
  input  logic [2:0]       cfgPerm,
  input  logic [SEG_W:0]   cfgLen,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOff,
  output logic [SEG_W:0]   lenQ,
  output logic             entValid,
  output logic [OFF_W-1:0] entLimit,
  output logic [2:0]       entPerm,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspAddr,
  output logic [2:0]       rspFault
);

  localparam int DEPTH = 1 << SEG_W;
  localparam int PAD   = PA_W - OFF_W;

  logic [PA_W-1:0]  baseMem  [DEPTH];
  logic [OFF_W-1:0] limitMem [DEPTH];
  logic [2:0]       permMem  [DEPTH];
  logic [DEPTH-1:0] validVec;

  // reads see contents before any write of this cycle
  assign entValid = validVec[reqSeg];
  assign entLimit = limitMem[reqSeg];
  assign entPerm  = permMem[reqSeg];

  always_ff @(posedge clk) begin
    if (ctrl.tblWr) begin
      baseMem[cfgIdx]  <= cfgBase;
      limitMem[cfgIdx] <= cfgLimit;
      permMem[cfgIdx]  <= cfgPerm;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validVec <= '0;
      lenQ     <= '0;
    end else begin
      if (ctrl.tblWr) validVec[cfgIdx] <= cfgValid;
      if (ctrl.lenWr) lenQ <= cfgLen;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspFault <= '0;
    end else if (ctrl.capture) begin
      rspValid <= 1'b1;
      rspFault <= ctrl.fault;
      rspAddr  <= (ctrl.fault == FLT_NONE) ?
                  baseMem[reqSeg] + {{PAD{1'b0}}, reqOff} : '0;
    end else begin
      rspValid <= 1'b0;
      rspAddr  <= '0;
      rspFault <= '0;
    end
  end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 8,
  parameter int OFF_W = 24,
  parameter int PA_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgSel,
  input  logic [SEG_W-1:0] cfgIdx,
  input  logic [PA_W-1:0]  cfgBase,
  input  logic [OFF_W-1:0] cfgLimit,
  input  logic             cfgValid,
  input  logic [2:0]       cfgPerm,
  input  logic [SEG_W:0]   cfgLen,
  input  logic             reqValid,
  input  logic [SEG_W-1:0] reqSeg,
  input  logic [OFF_W-1:0] reqOff,
  input  logic [1:0]       reqAcc,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspAddr,
  output logic [2:0]       rspFault
);

  ctrl_t            ctrl;
  logic [SEG_W:0]   lenQ;
  logic             entValid;
  logic [OFF_W-1:0] entLimit;
  logic [2:0]       entPerm;

  seg_xlate_ctrl #(.SEG_W(SEG_W), .OFF_W(OFF_W)) u_ctrl (
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .reqValid(reqValid),
    .reqSeg(reqSeg), .reqOff(reqOff), .reqAcc(reqAcc),
    .lenQ(lenQ), .entValid(entValid), .entLimit(entLimit),
    .entPerm(entPerm), .ctrl(ctrl)
  );

  seg_xlate_dp #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .cfgIdx(cfgIdx), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .cfgValid(cfgValid), .cfgPerm(cfgPerm), .cfgLen(cfgLen),
    .reqSeg(reqSeg), .reqOff(reqOff),
    .lenQ(lenQ), .entValid(entValid), .entLimit(entLimit),
    .entPerm(entPerm), .rspValid(rspValid), .rspAddr(rspAddr),
    .rspFault(rspFault)
  );

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int SEG_W = 8,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [SEG_W-1:0] reqSeg,
  input logic [SEG_W:0]   lenQ,
  input logic             entValid,
  input logic             rspValid,
  input logic [PA_W-1:0]  rspAddr,
  input logic [2:0]       rspFault
);

  // R2: response follows a request by one cycle
  p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R2: no response without a request
  p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R2: idle outputs are zero
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> (rspAddr == '0 && rspFault == 3'd0));

  // R3: out-of-range segment wins over every other check
  p_range_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqSeg} >= lenQ)) |=> rspFault == 3'd1);

  // R4: an in-range invalid entry reports code 2
  p_invalid_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ({1'b0, reqSeg} < lenQ) && !entValid) |=> rspFault == 3'd2);

  // R7: faulting responses carry a zero address
  p_fault_addr_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspFault != 3'd0) |-> rspAddr == '0);

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqSeg(reqSeg),
  .lenQ(u_dp.lenQ), .entValid(u_dp.entValid), .rspValid(rspValid),
  .rspAddr(rspAddr), .rspFault(rspFault)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [7:0]  cfgIdx = '0;
  logic [31:0] cfgBase = '0;
  logic [23:0] cfgLimit = '0;
  logic        cfgValid = 1'b0;
  logic [2:0]  cfgPerm = '0;
  logic [8:0]  cfgLen = '0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqSeg = '0;
  logic [23:0] reqOff = '0;
  logic [1:0]  reqAcc = '0;
  logic        rspValid;
  logic [31:0] rspAddr;
  logic [2:0]  rspFault;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [31:0] mBase [256];
  logic [23:0] mLim  [256];
  logic        mVal  [256];
  logic [2:0]  mPerm [256];
  logic [8:0]  mLen;

  always #(CLK_PERIOD/2) clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgBase(cfgBase), .cfgLimit(cfgLimit),
    .cfgValid(cfgValid), .cfgPerm(cfgPerm), .cfgLen(cfgLen),
    .reqValid(reqValid), .reqSeg(reqSeg), .reqOff(reqOff), .reqAcc(reqAcc),
    .rspValid(rspValid), .rspAddr(rspAddr), .rspFault(rspFault)
  );

  function automatic logic [2:0] expFault(logic [7:0] s, logic [23:0] o, logic [1:0] a);
    logic ok;
    if ({1'b0, s} >= mLen) return 3'd1;
    if (!mVal[s]) return 3'd2;
    if (o >= mLim[s]) return 3'd3;
    case (a)
      2'd0: ok = mPerm[s][0];
      2'd1: ok = mPerm[s][1];
      2'd2: ok = mPerm[s][2];
      default: ok = 1'b0;
    endcase
    return ok ? 3'd0 : 3'd4;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic writeEntry(logic [7:0] i, logic [31:0] b, logic [23:0] l,
                            logic v, logic [2:0] p);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b0; cfgIdx = i;
    cfgBase = b; cfgLimit = l; cfgValid = v; cfgPerm = p;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mBase[i] = b; mLim[i] = l; mVal[i] = v; mPerm[i] = p;
  endtask

  task automatic writeLen(logic [8:0] n);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgLen = n;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mLen = n;
  endtask

  // issue one request and check its response in the next cycle
  task automatic xlate(string tag, logic [7:0] s, logic [23:0] o, logic [1:0] a);
    logic [2:0]  ef;
    logic [31:0] ea;
    ef = expFault(s, o, a);
    ea = (ef == 3'd0) ? mBase[s] + {8'd0, o} : 32'd0;
    @(negedge clk);
    reqValid = 1'b1; reqSeg = s; reqOff = o; reqAcc = a;
    @(negedge clk);
    reqValid = 1'b0;
    check({tag, " valid"}, {63'd0, rspValid}, 64'd1);
    check({tag, " fault"}, {61'd0, rspFault}, {61'd0, ef});
    check({tag, " addr"}, {32'd0, rspAddr}, {32'd0, ea});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mBase[i] = '0; mLim[i] = '0; mVal[i] = 1'b0; mPerm[i] = '0;
    end
    mLen = '0;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 rspValid after reset", {63'd0, rspValid}, 64'd0);
    xlate("R1 request before length set", 8'd0, 24'd0, 2'd0);
    // R2: idle cycle after response
    @(negedge clk);
    check("R2 idle valid", {63'd0, rspValid}, 64'd0);
    check("R2 idle fault", {61'd0, rspFault}, 64'd0);

    writeEntry(8'd0, 32'h0010_0000, 24'h00_1000, 1'b1, 3'b001);
    writeEntry(8'd1, 32'hFFFF_F000, 24'h00_2000, 1'b1, 3'b111);
    writeEntry(8'd2, 32'h0000_0000, 24'h00_0010, 1'b0, 3'b111);
    writeEntry(8'd3, 32'h1234_0000, 24'h00_0100, 1'b1, 3'b100);
    writeLen(9'd4);

    // R3: range beats invalid/limit/permission
    xlate("R3 seg equals length", 8'd4, 24'hFF_FFFF, 2'd3);
    xlate("R3 seg max", 8'd255, 24'd0, 2'd0);
    // R4: invalid beats limit
    xlate("R4 invalid entry", 8'd2, 24'hFF_FFFF, 2'd3);
    // R5: limit boundary
    xlate("R5 offset at limit", 8'd0, 24'h00_1000, 2'd1);
    xlate("R7 offset limit minus one", 8'd0, 24'h00_0FFF, 2'd0);
    // R6: permissions
    xlate("R6 write denied", 8'd0, 24'h10, 2'd1);
    xlate("R6 exec denied", 8'd0, 24'h10, 2'd2);
    xlate("R6 acc3 denied", 8'd1, 24'h10, 2'd3);
    xlate("R6 exec allowed", 8'd3, 24'h20, 2'd2);
    xlate("R6 read denied", 8'd3, 24'h20, 2'd0);
    // R7: wraparound add
    xlate("R7 wrap add", 8'd1, 24'h00_1FFF, 2'd1);

    // R8: same-cycle write sees old contents, next sees new
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b0; cfgIdx = 8'd2;
    cfgBase = 32'h0A00_0000; cfgLimit = 24'h00_0100; cfgValid = 1'b1; cfgPerm = 3'b010;
    reqValid = 1'b1; reqSeg = 8'd2; reqOff = 24'h5; reqAcc = 2'd1;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    check("R8 same-cycle entry write uses old", {61'd0, rspFault}, 64'd2);
    mBase[2] = 32'h0A00_0000; mLim[2] = 24'h00_0100; mVal[2] = 1'b1; mPerm[2] = 3'b010;
    xlate("R8 entry write visible next", 8'd2, 24'h5, 2'd1);

    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = 1'b1; cfgLen = 9'd2;
    reqValid = 1'b1; reqSeg = 8'd3; reqOff = 24'h20; reqAcc = 2'd2;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    check("R8 same-cycle length write uses old", {61'd0, rspFault}, 64'd0);
    check("R8 same-cycle length addr", {32'd0, rspAddr}, 64'h1234_0020);
    mLen = 9'd2;
    xlate("R8 length write visible next", 8'd3, 24'h20, 2'd2);

    // random phase (R3..R7)
    for (int i = 0; i < 16; i++)
      writeEntry(i[7:0], $urandom, {8'd0, 16'($urandom)} + 24'd1,
                 1'($urandom % 5 != 0), 3'($urandom));
    writeLen(9'd256);
    writeEntry(8'd255, 32'h8000_0000, 24'hFF_FFFF, 1'b1, 3'b111);
    xlate("R3 full length top seg", 8'd255, 24'hFF_FFFE, 2'd0);
    writeLen(9'd12);
    for (int n = 0; n < 400; n++) begin
      logic [7:0]  s;
      logic [23:0] o;
      s = 8'($urandom % 16);
      case ($urandom % 3)
        0: o = mLim[s] - 24'd1;
        1: o = mLim[s];
        default: o = 24'($urandom) % (mLim[s] + 24'd1);
      endcase
      xlate("R7 random", s, o, 2'($urandom));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule